// File: doc/BRIEF.md
# PHY Test-Port Register Bridge

This block turns word writes from a host into the slow serial handshake that loads the control registers inside a display PHY. The host writes two words. The strobe word drives the PHY's clear and clock pins. The payload word drives the byte lines and the enable pin. The bridge holds every pin in a flop, so the pins change only on a clock edge and never glitch.

Loading one PHY register takes two phases. In the first phase the host places the register number on the byte lines with enable high, then pulses the clock. In the second phase it places the value with enable low and pulses the clock again. Each pulse is a write of 1 to the clock bit followed by a write of 0. The PHY captures on the falling edge of its test clock.

A behavioural model of the PHY's 256-entry register file sits behind the pins, so the complete handshake can be checked inside the block. The model's addressed entry is always visible on a readback output.

The host side is a valid/ready write channel. Ready is held high, so the bridge never applies back-pressure: every cycle with valid high is one accepted write, and valid may stay high on consecutive cycles.

Top module: `ptib_bridge`

## Requirements
- R1: After reset, phy_clr, phy_clk and phy_en are 0, phy_din is 0x00, and phy_dout is 0x00.
- R2: A strobe-word write (hst_sel=0) sets phy_clr from data bit 0 and phy_clk from data bit 1, one cycle after acceptance. A payload-word write (hst_sel=1) sets phy_din from data bits 7:0 and phy_en from data bit 16. Each word leaves the other word's pins unchanged.
- R3: hst_ready is always 1, and every cycle with hst_valid high is exactly one accepted write.
- R4: On a falling edge of phy_clk with phy_en=1 and phy_clr=0, the model takes phy_din as its current register address.
- R5: On a falling edge of phy_clk with phy_en=0 and phy_clr=0, the model writes phy_din into the register at the current address.
- R6: Nothing is captured while phy_clk rises or stays at a level. A change on phy_din or phy_en without a falling clock changes no model state.
- R7: While phy_clr is 1, every model register and the current address read as 0, and clear wins over a falling clock. The clear sequence is strobe words 0, then 1, then 0.
- R8: phy_dout always shows the contents of the register at the model's current address.
- R9: A full two-phase write loads the value into the named register and leaves every other register unchanged. Address 0x10000 plus the register number written as a payload word selects the address phase.
- R10: Data bits other than 0 and 1 of the strobe word, and bits other than 7:0 and 16 of the payload word, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host write valid |
| hst_ready | output | 1 | Host write ready, held at 1 |
| hst_sel | input | 1 | Selects the word: 0 strobe word, 1 payload word |
| hst_wdata | input | 32 | Host write data |
| phy_clr | output | 1 | PHY test clear pin |
| phy_clk | output | 1 | PHY test clock pin |
| phy_en | output | 1 | PHY test enable pin (address phase when 1) |
| phy_din | output | 8 | PHY test data-in byte |
| phy_dout | output | 8 | Readback of the model's addressed register |

## Verification
The assertions check these rules on every cycle:
- the pin response to each kind of word, and pin stability on idle cycles;
- that a clear leaves the readback at zero;
- that the readback holds unless a falling clock or a clear occurs;
- that a data-phase falling edge lands the byte on the readback.

Address selection, and whether untouched registers keep their contents across many writes, cannot be seen from one cycle. Only the bench's sequences show them. The bench runs random address/value pairs against a reference copy, reads back chosen addresses including 0x00 and 0xFF, and drives directed cases: a rising clock alone, the byte lines changing without a strobe, and writes with the ignored bits set.

// File: rtl/ptib_pkg.sv
package ptib_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned CLR_BIT = 0;
  localparam int unsigned CLK_BIT = 1;
  localparam int unsigned EN_BIT  = 16;

  typedef struct packed {
    logic              clr;
    logic              clk;
    logic              en;
    logic [BYTE_W-1:0] din;
  } ptib_pins_t;
endpackage

// File: rtl/ptib_host_regs.sv
module ptib_host_regs
  import ptib_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output ptib_pins_t   pins
);
  ptib_pins_t pins_q;
  logic       unused_bits;

  assign unused_bits = ^{wr_data[W-1:EN_BIT+1], wr_data[EN_BIT-1:BYTE_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q <= '0;
    end else if (wr_valid) begin
      if (wr_sel) begin
        pins_q.din <= wr_data[BYTE_W-1:0];
        pins_q.en  <= wr_data[EN_BIT];
      end else begin
        pins_q.clr <= wr_data[CLR_BIT];
        pins_q.clk <= wr_data[CLK_BIT];
      end
    end
  end

  assign pins = pins_q;
endmodule

// File: rtl/ptib_phy_model.sv
module ptib_phy_model
  import ptib_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclr,
  input  logic          tclk,
  input  logic          ten,
  input  logic [DW-1:0] tdin,
  output logic [DW-1:0] tdout
);
  localparam int unsigned DEPTH = 1 << AW;

  logic          tclk_d;
  logic          fall;
  logic          addr_ld;
  logic          data_ld;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cells [DEPTH];

  assign fall    = tclk_d & ~tclk;
  assign addr_ld = fall & ten & ~tclr;
  assign data_ld = fall & ~ten & ~tclr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tclk_d <= 1'b0;
      addr_q <= '0;
    end else begin
      tclk_d <= tclk;
      if (tclr)         addr_q <= '0;
      else if (addr_ld) addr_q <= tdin[AW-1:0];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [DW-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n || tclr)                              cell_q <= '0;
      else if (data_ld && addr_q == AW'(i))            cell_q <= tdin;
    end
    assign cells[i] = cell_q;
  end

  assign tdout = cells[addr_q];
endmodule

// File: rtl/ptib_bridge.sv
module ptib_bridge
  import ptib_pkg::*;
#(
  parameter int unsigned W  = BUS_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic              hst_sel,
  input  logic [W-1:0]      hst_wdata,
  output logic              phy_clr,
  output logic              phy_clk,
  output logic              phy_en,
  output logic [BYTE_W-1:0] phy_din,
  output logic [BYTE_W-1:0] phy_dout
);
  ptib_pins_t pins;

  assign hst_ready = 1'b1;

  ptib_host_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (hst_valid & hst_ready),
    .wr_sel   (hst_sel),
    .wr_data  (hst_wdata),
    .pins     (pins)
  );

  ptib_phy_model #(.AW(AW), .DW(BYTE_W)) u_model (
    .clk   (clk),
    .rst_n (rst_n),
    .tclr  (pins.clr),
    .tclk  (pins.clk),
    .ten   (pins.en),
    .tdin  (pins.din),
    .tdout (phy_dout)
  );

  assign phy_clr = pins.clr;
  assign phy_clk = pins.clk;
  assign phy_en  = pins.en;
  assign phy_din = pins.din;
endmodule

// File: rtl/ptib_checker.sv
module ptib_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hst_valid,
  input logic        hst_ready,
  input logic        hst_sel,
  input logic [31:0] hst_wdata,
  input logic        phy_clr,
  input logic        phy_clk,
  input logic        phy_en,
  input logic [7:0]  phy_din,
  input logic [7:0]  phy_dout
);
  AST_ACCEPT_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    hst_valid |-> hst_ready); // R3

  AST_STROBE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && !hst_sel) |=> (phy_clr == $past(hst_wdata[0]) &&
                                 phy_clk == $past(hst_wdata[1]) &&
                                 $stable(phy_en) && $stable(phy_din))); // R2

  AST_PAYLOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && hst_sel) |=> (phy_din == $past(hst_wdata[7:0]) &&
                                phy_en == $past(hst_wdata[16]) &&
                                $stable(phy_clr) && $stable(phy_clk))); // R2

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_valid |=> ($stable(phy_clr) && $stable(phy_clk) &&
                    $stable(phy_en) && $stable(phy_din))); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    phy_clr |=> phy_dout == 8'h00); // R7

  AST_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!($past(phy_clk) && !phy_clk) && !phy_clr) |=> $stable(phy_dout)); // R6

  AST_DATA_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phy_clk) && !phy_clk && !phy_en && !phy_clr) |=>
      phy_dout == $past(phy_din)); // R5
endmodule

bind ptib_bridge ptib_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hst_valid (hst_valid),
  .hst_ready (hst_ready),
  .hst_sel   (hst_sel),
  .hst_wdata (hst_wdata),
  .phy_clr   (phy_clr),
  .phy_clk   (phy_clk),
  .phy_en    (phy_en),
  .phy_din   (phy_din),
  .phy_dout  (phy_dout)
);

// File: tb/tb_ptib_bridge.sv
module tb_ptib_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0;
  logic        hst_ready;
  logic        hst_sel = 1'b0;
  logic [31:0] hst_wdata = '0;
  logic        phy_clr, phy_clk, phy_en;
  logic [7:0]  phy_din, phy_dout;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [256];

  always #4 clk = ~clk;

  ptib_bridge dut (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_ready(hst_ready),
    .hst_sel(hst_sel), .hst_wdata(hst_wdata), .phy_clr(phy_clr),
    .phy_clk(phy_clk), .phy_en(phy_en), .phy_din(phy_din), .phy_dout(phy_dout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic sel, input logic [31:0] data);
    @(negedge clk);
    hst_valid = 1'b1; hst_sel = sel; hst_wdata = data;
    @(negedge clk);
    hst_valid = 1'b0; hst_wdata = '0;
  endtask

  task automatic pulse();
    put(1'b0, 32'h2);
    put(1'b0, 32'h0);
  endtask

  function automatic logic [31:0] addr_word(input logic [7:0] a);
    return 32'h10000 + {24'h0, a};
  endfunction

  task automatic phy_write(input logic [7:0] a, input logic [7:0] v);
    put(1'b1, addr_word(a)); pulse();
    put(1'b1, {24'h0, v});   pulse();
    ref_mem[a] = v;
  endtask

  task automatic phy_read(input logic [7:0] a, output logic [7:0] v);
    put(1'b1, addr_word(a)); pulse();
    @(negedge clk); @(negedge clk);
    v = phy_dout;
  endtask

  task automatic phy_clear();
    put(1'b0, 32'h0); put(1'b0, 32'h1); put(1'b0, 32'h0);
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int unsigned seed;
    seed = $urandom(32'd5150);
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pins", {29'h0, phy_clr, phy_clk, phy_en}, 32'h0);
    chk("R1 din", {24'h0, phy_din}, 32'h0);
    chk("R1 dout", {24'h0, phy_dout}, 32'h0);
    chk("R3 ready", {31'h0, hst_ready}, 32'h1);

    // R2 / R10 strobe word with ignored bits set: clr=1 clk=0
    put(1'b0, 32'hFFFF_FFFD);
    chk("R2 R10 strobe", {30'h0, phy_clr, phy_clk}, 32'h2);
    chk("R2 payload untouched", {23'h0, phy_en, phy_din}, 32'h0);
    put(1'b0, 32'h0);
    // payload word with en=0 and other bits set
    put(1'b1, 32'hFFFE_FFA5);
    chk("R2 R10 payload", {23'h0, phy_en, phy_din}, 32'h0A5);
    chk("R2 strobe untouched", {30'h0, phy_clr, phy_clk}, 32'h0);
    put(1'b1, 32'hFFFF_0F3C);
    chk("R2 R10 payload en", {23'h0, phy_en, phy_din}, 32'h13C);

    // R9 directed write, R8 readback
    phy_write(8'h05, 8'h3C);
    phy_read(8'h05, rd);
    chk("R8 R9 reg5", {24'h0, rd}, 32'h3C);
    // R6 byte change without strobe
    put(1'b1, 32'h0000_0077);
    @(negedge clk); @(negedge clk);
    chk("R6 no strobe", {24'h0, phy_dout}, 32'h3C);
    put(1'b0, 32'h2);
    @(negedge clk); @(negedge clk);
    chk("R6 rising only", {24'h0, phy_dout}, 32'h3C);
    put(1'b0, 32'h0);
    @(negedge clk);
    chk("R5 falling data", {24'h0, phy_dout}, 32'h77);
    ref_mem[5] = 8'h77;

    // R4 address selection switches the readback
    phy_write(8'hFF, 8'hE1);
    phy_write(8'h00, 8'h1E);
    phy_read(8'hFF, rd);
    chk("R4 addr FF", {24'h0, rd}, 32'hE1);
    phy_read(8'h00, rd);
    chk("R4 addr 00", {24'h0, rd}, 32'h1E);

    // R9 random pairs against reference
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a, v;
      a = 8'($urandom); v = 8'($urandom);
      phy_write(a, v);
    end
    for (int n = 0; n < 16; n++) begin
      logic [7:0] a;
      a = 8'($urandom);
      phy_read(a, rd);
      chk("R9 random", {24'h0, rd}, {24'h0, ref_mem[a]});
    end
    phy_read(8'h05, rd);
    chk("R9 reg5 kept", {24'h0, rd}, {24'h0, ref_mem[5]});

    // R7 clear
    phy_write(8'h80, 8'h99);
    phy_clear();
    chk("R7 dout after clear", {24'h0, phy_dout}, 32'h0);
    phy_read(8'h80, rd);
    chk("R7 reg80", {24'h0, rd}, 32'h0);
    phy_read(8'hFF, rd);
    chk("R7 regFF", {24'h0, rd}, 32'h0);

    // R3 back-to-back writes all accepted
    @(negedge clk);
    hst_valid = 1'b1; hst_sel = 1'b1; hst_wdata = 32'h0000_0011;
    @(negedge clk);
    hst_wdata = 32'h0001_0022;
    @(negedge clk);
    hst_valid = 1'b0;
    chk("R3 back-to-back", {23'h0, phy_en, phy_din}, 32'h122);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule